// File: doc/BRIEF.md
# Two-Wire Slave Front-End for a Data-Acquisition Converter

This block is the serial-bus front end of a small converter chip. It watches the open-drain SCL and SDA lines, finds start and stop conditions, and receives the address byte. It answers only when the address matches its own: a fixed upper part plus three strap pins. Which register a write byte lands in depends on its position after the address. The first byte goes to a control register. Every byte after that goes to a DAC data register.

In a read transfer the block returns ADC result bytes. At the trailing edge of each acknowledge clock that precedes a byte, it takes the ADC result present at its input, starts shifting that value out, and pulses a conversion-start strobe. The new conversion therefore runs while the previous result is on the wire. The block keeps sending bytes while the master acknowledges. On a not-acknowledge it releases the bus.

Both bus lines are oversampled by the system clock through synchronisers. All bit timing is taken from edges detected on the synchronised copies.

Top module: `acq_i2c_regif`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), `ctrl_o`=0, `dac_o`=0 and `conv_start_o`=0.
- R2: The 7-bit device address is {ADDR_FIXED (default 4'b1001), addr_sel_i[2:0]}, sent MSB first, with the eighth bit giving the direction (0 write, 1 read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: A non-matching address gets no acknowledge. The block then leaves SDA released and ignores all further bytes until the next start condition, so no register changes.
- R4: In a write transfer, the first byte after the address (MSB first) is loaded into `ctrl_o` and acknowledged.
- R5: In a write transfer, every later byte is loaded into `dac_o` and acknowledged; the last such byte wins, and `ctrl_o` keeps its value.
- R6: After a read address is acknowledged, `conv_start_o` pulses for exactly one clock cycle. The pulse comes only after the falling SCL edge that ends the acknowledge clock, never before it.
- R7: Each read byte is the value `adc_result_i` held at the acknowledge trailing edge just before it, sent MSB first. A master ACK (SDA low on the ninth clock) produces a further strobe and byte. A NACK produces no strobe, and SDA stays released.
- R8: A start condition at any point restarts address reception, including a repeated start between a write and a read. A stop condition returns the block to idle. A write byte cut short by a start or stop changes no register.
- R9: `sda_oe_o` changes only in the cycle after a synchronised SCL fall, start or stop, so the data the block drives is stable while SCL is high.
- R10: `conv_start_o` never pulses during a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel_i | input | 3 | Strap pins giving the low three address bits |
| adc_result_i | input | 8 | Latest ADC conversion result |
| ctrl_o | output | 8 | Control register contents |
| dac_o | output | 8 | DAC data register contents |
| conv_start_o | output | 1 | One-cycle strobe that starts an ADC conversion |

## Verification
The assertions assume that SCL and SDA are legal bus waveforms. SDA may change only while SCL is low, except when forming a start or stop. Each SCL level must last much longer than the synchroniser delay, so that edge order survives sampling. The stimulus uses a bit period of forty system clocks and moves SDA only in the middle of the SCL low phase. The bench's ADC model always finishes its conversion well inside one byte time, so the value captured at each acknowledge edge is settled.

// File: rtl/acq_i2c_pkg.sv
package acq_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int FIX_W  = 4;
  localparam int DEV_W  = FIX_W + SEL_W;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SACK,
    PH_WRX,
    PH_RDX,
    PH_MACK
  } phase_t;
endpackage

// File: rtl/acq_line_sync.sv
module acq_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/acq_reg_bank.sv
module acq_reg_bank
  import acq_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] dac_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      dac_o  <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i) dac_o  <= wr_data_i;
      else          ctrl_o <= wr_data_i;
    end
  end

  // R4: the control register moves only on a first-byte write
  a_r4_ctrl_on_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> $past(wr_en_i && !wr_sel_i));
  // R5: the DAC register moves only on a later-byte write
  a_r5_dac_on_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_o) |-> $past(wr_en_i && wr_sel_i));
endmodule

// File: rtl/acq_i2c_ctrl.sv
module acq_i2c_ctrl
  import acq_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [BYTE_W-1:0] adc_i,
  output logic              sda_oe_o,
  output logic              conv_o,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  phase_t              phase_q;
  logic [CNT_W-1:0]    bit_q;
  logic [BYTE_W-2:0]   rx_q;
  logic [BYTE_W-1:0]   tx_q;
  logic                rd_q;
  logic                ack_half_q;
  logic                later_q;
  logic                mack_q;
  logic                start_c;
  logic                stop_c;
  logic                last_bit;

  assign start_c  = scl_lvl_i & sda_fall_i;
  assign stop_c   = scl_lvl_i & sda_rise_i;
  assign last_bit = (bit_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rd_q       <= 1'b0;
      ack_half_q <= 1'b0;
      later_q    <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      conv_o     <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_sel_o   <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      conv_o  <= 1'b0;
      wr_en_o <= 1'b0;
      if (start_c) begin
        phase_q  <= PH_ADDR;
        bit_q    <= '0;
        later_q  <= 1'b0;
        rd_q     <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        phase_q  <= PH_IDLE;
        rd_q     <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (scl_rise_i) begin
            rx_q  <= {rx_q[BYTE_W-3:0], sda_lvl_i};
            bit_q <= bit_q + CNT_W'(1);
            if (last_bit) begin
              if (rx_q == dev_addr_i) begin
                phase_q    <= PH_SACK;
                rd_q       <= sda_lvl_i;
                ack_half_q <= 1'b0;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          PH_SACK: if (scl_fall_i) begin
            if (!ack_half_q) begin
              sda_oe_o   <= 1'b1;
              ack_half_q <= 1'b1;
            end else begin
              ack_half_q <= 1'b0;
              bit_q      <= '0;
              if (rd_q) begin
                conv_o   <= 1'b1;
                tx_q     <= adc_i;
                sda_oe_o <= ~adc_i[BYTE_W-1];
                phase_q  <= PH_RDX;
              end else begin
                sda_oe_o <= 1'b0;
                phase_q  <= PH_WRX;
              end
            end
          end
          PH_WRX: if (scl_rise_i) begin
            rx_q  <= {rx_q[BYTE_W-3:0], sda_lvl_i};
            bit_q <= bit_q + CNT_W'(1);
            if (last_bit) begin
              wr_en_o    <= 1'b1;
              wr_sel_o   <= later_q;
              wr_data_o  <= {rx_q, sda_lvl_i};
              later_q    <= 1'b1;
              ack_half_q <= 1'b0;
              phase_q    <= PH_SACK;
            end
          end
          PH_RDX: if (scl_fall_i) begin
            if (last_bit) begin
              sda_oe_o <= 1'b0;
              phase_q  <= PH_MACK;
            end else begin
              tx_q     <= tx_q << 1;
              sda_oe_o <= ~tx_q[BYTE_W-2];
              bit_q    <= bit_q + CNT_W'(1);
            end
          end
          PH_MACK: begin
            if (scl_rise_i) mack_q <= ~sda_lvl_i;
            if (scl_fall_i) begin
              if (mack_q) begin
                conv_o   <= 1'b1;
                tx_q     <= adc_i;
                sda_oe_o <= ~adc_i[BYTE_W-1];
                bit_q    <= '0;
                phase_q  <= PH_RDX;
              end else begin
                rd_q    <= 1'b0;
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a strobe follows a synchronised SCL fall
  a_r6_conv_after_fall: assert property (@(posedge clk) disable iff (rst)
    conv_o |-> $past(scl_fall_i));
  // R6: the strobe lasts one cycle
  a_r6_conv_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_o |=> !conv_o);
  // R10: no strobe unless the transfer is a read
  a_r10_conv_read_only: assert property (@(posedge clk) disable iff (rst)
    conv_o |-> rd_q);
  // R9: SDA drive changes only after SCL fall, start or stop
  a_r9_sda_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> $past(scl_fall_i || start_c || stop_c));
  // R3: idle never drives the bus
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/acq_i2c_regif.sv
module acq_i2c_regif
  import acq_i2c_pkg::*;
#(
  parameter logic [FIX_W-1:0] ADDR_FIXED  = 4'b1001,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [BYTE_W-1:0] adc_result_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] dac_o,
  output logic              conv_start_o
);
  localparam int LINES = 2;
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] fall;
  logic             wr_en;
  logic             wr_sel;
  logic [BYTE_W-1:0] wr_data;
  logic [DEV_W-1:0] dev_addr;

  assign raw[L_SCL] = scl_i;
  assign raw[L_SDA] = sda_i;
  assign dev_addr   = {ADDR_FIXED, addr_sel_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    acq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_i  (raw[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  acq_i2c_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl_i  (lvl[L_SCL]),
    .scl_rise_i (rise[L_SCL]),
    .scl_fall_i (fall[L_SCL]),
    .sda_lvl_i  (lvl[L_SDA]),
    .sda_rise_i (rise[L_SDA]),
    .sda_fall_i (fall[L_SDA]),
    .dev_addr_i (dev_addr),
    .adc_i      (adc_result_i),
    .sda_oe_o   (sda_oe_o),
    .conv_o     (conv_start_o),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .wr_data_o  (wr_data)
  );

  acq_reg_bank u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .ctrl_o    (ctrl_o),
    .dac_o     (dac_o)
  );
endmodule

// File: tb/acq_i2c_regif_tb.sv
module acq_i2c_regif_tb;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [7:0] adc = 8'h80;
  logic       sda_oe;
  logic [7:0] ctrl;
  logic [7:0] dac;
  logic       conv;
  logic       sda_line;

  int total = 0;
  int bad = 0;
  int conv_seen = 0;
  int n_exp = 0;
  bit done = 1'b0;
  bit unstable = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] rd_val;
  event       rd_ev;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  acq_i2c_regif u_dut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .addr_sel_i   (pins),
    .adc_result_i (adc),
    .ctrl_o       (ctrl),
    .dac_o        (dac),
    .conv_start_o (conv)
  );

  // ADC model: each started conversion adds 8'h1D after 30 cycles
  always @(negedge clk) begin : adc_model
    static int cnt = 0;
    if (conv) begin
      conv_seen++;
      cnt = 30;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) adc <= adc + 8'h1D;
    end
  end

  function automatic logic [7:0] adc_after(int n);
    return 8'(8'h80 + 8'h1D * n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(rd_ev) begin
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL R7 unexpected byte act=%0h exp=none", rd_val);
    end else begin
      check("R7 read byte", 32'(rd_val), 32'(exp_q.pop_front()));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(H/2); sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(H/2); sda_m = 1'b0; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(logic b);
    tick(H/2); sda_m = b; tick(H/2);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    logic s2;
    tick(H/2); sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H/4);
    b = sda_line; tick(H/2);
    s2 = sda_line; tick(H/4);
    if (s2 !== b) unstable = 1'b1;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] v;
    logic b;
    exp_q.push_back(adc_after(n_exp));
    n_exp++;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(give_ack ? 1'b0 : 1'b1);
    rd_val = v;
    ->rd_ev;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    int c0;
    tick(5);
    rst = 1'b0;
    tick(3);
    // R1 reset state
    check("R1 sda_oe", 32'(sda_oe), 0);
    check("R1 ctrl", 32'(ctrl), 0);
    check("R1 dac", 32'(dac), 0);
    check("R1 conv", 32'(conv), 0);

    // write: address 1001101 + W = 8'h9A
    bus_start();
    send_byte(8'h9A, ack); check("R2 address ack", 32'(ack), 1);
    send_byte(8'h45, ack); check("R4 ctrl ack", 32'(ack), 1);
    check("R4 ctrl value", 32'(ctrl), 32'h45);
    send_byte(8'hA7, ack); check("R5 dac ack", 32'(ack), 1);
    check("R5 dac value", 32'(dac), 32'hA7);
    send_byte(8'h3C, ack); check("R5 second dac ack", 32'(ack), 1);
    check("R5 dac last wins", 32'(dac), 32'h3C);
    check("R5 ctrl kept", 32'(ctrl), 32'h45);
    bus_stop();
    check("R10 no strobe in write", 32'(conv_seen), 0);

    // wrong low bits and wrong fixed part
    bus_start();
    send_byte(8'h9E, ack); check("R3 low-bit mismatch nack", 32'(ack), 0);
    send_byte(8'h11, ack); check("R3 byte ignored", 32'(ack), 0);
    check("R3 ctrl unchanged", 32'(ctrl), 32'h45);
    check("R3 sda released", 32'(sda_oe), 0);
    bus_stop();
    bus_start();
    send_byte(8'h1A, ack); check("R3 fixed-part mismatch nack", 32'(ack), 0);
    bus_stop();

    // new strap value: address 1001010 -> 8'h94 / 8'h95
    pins = 3'b010;
    bus_start();
    send_byte(8'h9A, ack); check("R2 old address now rejected", 32'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'h94, ack); check("R2 new address ack", 32'(ack), 1);
    send_byte(8'h06, ack); check("R4 ctrl after strap change", 32'(ctrl), 32'h06);
    bus_stop();

    // read three bytes
    c0 = conv_seen;
    bus_start();
    send_byte(8'h95, ack); check("R2 read address ack", 32'(ack), 1);
    check("R6 no strobe before ack fall", 32'(conv_seen), 32'(c0));
    tick(8);
    check("R6 one strobe after ack fall", 32'(conv_seen), 32'(c0 + 1));
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    tick(8);
    check("R7 strobes per ack", 32'(conv_seen), 32'(c0 + 3));
    check("R7 released after nack", 32'(sda_oe), 0);
    bus_stop();
    check("R9 read data stable while SCL high", 32'(unstable), 0);

    // interrupted write byte
    bus_start();
    send_byte(8'h94, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check("R8 cut byte ignored", 32'(ctrl), 32'h06);

    // repeated start from write into read
    bus_start();
    send_byte(8'h94, ack);
    send_byte(8'h21, ack); check("R8 ctrl before restart", 32'(ctrl), 32'h21);
    bus_start();
    send_byte(8'h95, ack); check("R8 restart read ack", 32'(ack), 1);
    recv_byte(1'b0);
    bus_stop();
    tick(8);
    check("R8 strobe count after restart", 32'(conv_seen), 32'(c0 + 4));
    check("R8 scoreboard drained", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule